// File: doc/BRIEF.md
# Static Dual-Issue Packet Splitter

This block sits between instruction fetch and two execution lanes of a 32-bit RISC-V style core that issues two instructions per cycle under compiler control. Every fetch delivers one 64-bit word that holds one issue packet. The lower-addressed half belongs to the ALU/branch lane and the upper half belongs to the load/store lane. The block owns the fetch program counter. It decodes the major opcode of each half and checks that each half suits its lane. It then hands both halves to the lanes one cycle later, each with its own valid bit. A slot that holds the canonical nop is handed on with its valid bit low.

The block deliberately compares no registers between the two slots or between successive packets. The compiler is trusted to have ordered the stream, which includes honouring the single load delay slot. With both slots filled on every cycle, throughput is two instructions per clock.

Packets that cannot issue are still consumed and the counter still moves. One case is a packet fetched from an address that is not a multiple of 8. The other is a packet whose halves do not match their lanes. Each case raises its own error flag and leaves both lanes idle.

Top module: `pkt_issue_split`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises with no fetch, both lane valid bits and both error flags are 0, and fetch_pc_o equals RESET_PC (default 0).
- R2: One cycle after a fetch is accepted (fetch_valid_i high at a rising edge), alu_instr_o carries fetch_word_i[31:0] and mem_instr_o carries fetch_word_i[63:32].
- R3: The ALU lane accepts major opcodes (bits 6:0) 0110011 and 0010011 as plain ALU work, and 1100011, 1101111 and 1100111 as control transfers. For these last three, alu_branch_o is 1; otherwise it is 0.
- R4: The memory lane accepts major opcodes 0000011 (load) and 0100011 (store). mem_store_o is 1 for a store and 0 for a load.
- R5: The word 32'h00000013 in either slot is a nop. That lane's valid bit stays 0, the other lane is unaffected, and no flag is raised. Any other OP-IMM word, such as 32'h00100013, is ordinary ALU work.
- R6: When either half has an opcode its lane does not accept, illegal_o is 1 for one cycle and both lane valid bits are 0. This covers a memory opcode in the lower half, an ALU or control opcode in the upper half, and any unlisted opcode in either half.
- R7: When a fetch is accepted while fetch_pc_o[2:0] is not 000, misalign_o is 1 and illegal_o and both lane valid bits are 0. This holds whatever the packet contains.
- R8: An accepted fetch without branch_taken_i advances fetch_pc_o by 8 on the same edge. This applies even when the packet is illegal, misaligned or all nop.
- R9: An accepted fetch with branch_taken_i high loads fetch_pc_o with branch_target_i on the same edge.
- R10: A cycle without an accepted fetch leaves fetch_pc_o unchanged and gives both valid bits and both flags at 0 one cycle later.
- R11: There is no hazard check. A packet that reads the destination of a load in the previous packet still issues, one cycle after that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | fetch_word_i holds the packet at fetch_pc_o |
| fetch_word_i | input | 64 | Issue packet, lower half is the ALU slot |
| branch_taken_i | input | 1 | Redirect the counter for this packet |
| branch_target_i | input | AW | Redirect address |
| fetch_pc_o | output | AW | Address of the packet to fetch |
| alu_valid_o | output | 1 | ALU lane has work |
| alu_instr_o | output | 32 | ALU lane instruction |
| alu_branch_o | output | 1 | ALU lane instruction is a control transfer |
| mem_valid_o | output | 1 | Memory lane has work |
| mem_instr_o | output | 32 | Memory lane instruction |
| mem_store_o | output | 1 | Memory lane instruction is a store |
| misalign_o | output | 1 | Previous packet was fetched from a misaligned address |
| illegal_o | output | 1 | Previous packet had a slot mismatch |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a reset address of 0. With these settings the counter values stay small, and a branch to 0x104 is enough to reach the misalignment path. The directed packets cover every accepted opcode in its own lane and each kind of crossed or unknown opcode. They also cover nop in either slot and in both slots, and the near-nop ADDI x0,x0,1. Two further cases are a load followed directly by its consumer, and a mismatched packet fetched from a misaligned address, where misalignment must win.

// File: rtl/pkt_issue_pkg.sv
package pkt_issue_pkg;
  localparam int unsigned ILEN = 32;
  localparam int unsigned SLOTS = 2;
  localparam int unsigned PKT_W = ILEN * SLOTS;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [ILEN-1:0] NOP_WORD = 32'h0000_0013;

  typedef enum logic [2:0] {
    CLS_NOP, CLS_ALU, CLS_CTRL, CLS_LOAD, CLS_STORE, CLS_BAD
  } insn_cls_e;

  typedef enum logic {SLOT_ALU, SLOT_MEM} slot_kind_e;

  function automatic insn_cls_e classify(input logic [ILEN-1:0] w);
    if (w == NOP_WORD) return CLS_NOP;
    unique case (w[6:0])
      OPC_OP, OPC_OPIMM:            return CLS_ALU;
      OPC_BRANCH, OPC_JAL, OPC_JALR: return CLS_CTRL;
      OPC_LOAD:                     return CLS_LOAD;
      OPC_STORE:                    return CLS_STORE;
      default:                      return CLS_BAD;
    endcase
  endfunction
endpackage

// File: rtl/pkt_slot_decode.sv
module pkt_slot_decode
  import pkt_issue_pkg::*;
#(
  parameter slot_kind_e KIND = SLOT_ALU
) (
  input  logic [ILEN-1:0] instr_i,
  output logic            empty_o,
  output logic            legal_o,
  output logic            flavor_o
);
  insn_cls_e cls;

  always_comb cls = classify(instr_i);

  assign empty_o = (cls == CLS_NOP);

  generate
    if (KIND == SLOT_ALU) begin : g_alu
      assign legal_o  = (cls == CLS_NOP) || (cls == CLS_ALU) || (cls == CLS_CTRL);
      assign flavor_o = (cls == CLS_CTRL);
    end else begin : g_mem
      assign legal_o  = (cls == CLS_NOP) || (cls == CLS_LOAD) || (cls == CLS_STORE);
      assign flavor_o = (cls == CLS_STORE);
    end
  endgenerate
endmodule

// File: rtl/pkt_pc_gen.sv
module pkt_pc_gen #(
  parameter int unsigned       AW        = 32,
  parameter int unsigned       PKT_BYTES = 8,
  parameter logic [AW-1:0]     RESET_PC  = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          taken_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o,
  output logic          misalign_o
);
  localparam int unsigned OFS_W = $clog2(PKT_BYTES);
  localparam logic [AW-1:0] STEP = AW'(PKT_BYTES);

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= RESET_PC;
    else if (adv_i)   pc_q <= taken_i ? target_i : pc_q + STEP;
  end

  assign pc_o       = pc_q;
  assign misalign_o = |pc_q[OFS_W-1:0];
endmodule

// File: rtl/pkt_issue_split.sv
module pkt_issue_split
  import pkt_issue_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_valid_i,
  input  logic [PKT_W-1:0] fetch_word_i,
  input  logic             branch_taken_i,
  input  logic [AW-1:0]    branch_target_i,
  output logic [AW-1:0]    fetch_pc_o,
  output logic             alu_valid_o,
  output logic [ILEN-1:0]  alu_instr_o,
  output logic             alu_branch_o,
  output logic             mem_valid_o,
  output logic [ILEN-1:0]  mem_instr_o,
  output logic             mem_store_o,
  output logic             misalign_o,
  output logic             illegal_o
);
  localparam int unsigned PKT_BYTES = PKT_W / 8;

  logic [SLOTS-1:0] slot_empty, slot_legal, slot_flavor;
  logic             pc_misalign;
  logic             pkt_legal, issue_ok;

  pkt_pc_gen #(.AW(AW), .PKT_BYTES(PKT_BYTES), .RESET_PC(RESET_PC)) i_pc_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (fetch_valid_i),
    .taken_i    (branch_taken_i),
    .target_i   (branch_target_i),
    .pc_o       (fetch_pc_o),
    .misalign_o (pc_misalign)
  );

  // slot 0 sits at the lower address and feeds the ALU lane
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam slot_kind_e K = (g == 0) ? SLOT_ALU : SLOT_MEM;
    pkt_slot_decode #(.KIND(K)) i_dec (
      .instr_i  (fetch_word_i[g*ILEN +: ILEN]),
      .empty_o  (slot_empty[g]),
      .legal_o  (slot_legal[g]),
      .flavor_o (slot_flavor[g])
    );
  end

  assign pkt_legal = &slot_legal;
  assign issue_ok  = fetch_valid_i && !pc_misalign && pkt_legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alu_valid_o  <= 1'b0;
      mem_valid_o  <= 1'b0;
      misalign_o   <= 1'b0;
      illegal_o    <= 1'b0;
      alu_instr_o  <= NOP_WORD;
      mem_instr_o  <= NOP_WORD;
      alu_branch_o <= 1'b0;
      mem_store_o  <= 1'b0;
    end else begin
      alu_valid_o <= issue_ok && !slot_empty[0];
      mem_valid_o <= issue_ok && !slot_empty[1];
      misalign_o  <= fetch_valid_i && pc_misalign;
      illegal_o   <= fetch_valid_i && !pc_misalign && !pkt_legal;
      if (fetch_valid_i) begin
        alu_instr_o  <= fetch_word_i[ILEN-1:0];
        mem_instr_o  <= fetch_word_i[PKT_W-1:ILEN];
        alu_branch_o <= slot_flavor[0];
        mem_store_o  <= slot_flavor[1];
      end
    end
  end
endmodule

// File: rtl/pkt_issue_split_chk.sv
module pkt_issue_split_chk
  import pkt_issue_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fetch_valid_i,
  input logic            branch_taken_i,
  input logic [AW-1:0]   branch_target_i,
  input logic [AW-1:0]   fetch_pc_o,
  input logic            alu_valid_o,
  input logic [ILEN-1:0] alu_instr_o,
  input logic            mem_valid_o,
  input logic [ILEN-1:0] mem_instr_o,
  input logic            misalign_o,
  input logic            illegal_o
);
  p_nop_not_issued_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o |-> alu_instr_o != NOP_WORD);

  p_mem_lane_opcode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_instr_o[6:0] == OPC_LOAD || mem_instr_o[6:0] == OPC_STORE));

  p_illegal_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !alu_valid_o && !mem_valid_o);

  p_misalign_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !alu_valid_o && !mem_valid_o && !illegal_o);

  p_pc_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(fetch_valid_i) && !$past(branch_taken_i))
      |-> fetch_pc_o == $past(fetch_pc_o) + AW'(8));

  p_pc_redirect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(fetch_valid_i) && $past(branch_taken_i))
      |-> fetch_pc_o == $past(branch_target_i));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(fetch_valid_i))
      |-> $stable(fetch_pc_o) && !alu_valid_o && !mem_valid_o && !misalign_o && !illegal_o);
endmodule

bind pkt_issue_split pkt_issue_split_chk #(.AW(AW)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fetch_valid_i   (fetch_valid_i),
  .branch_taken_i  (branch_taken_i),
  .branch_target_i (branch_target_i),
  .fetch_pc_o      (fetch_pc_o),
  .alu_valid_o     (alu_valid_o),
  .alu_instr_o     (alu_instr_o),
  .mem_valid_o     (mem_valid_o),
  .mem_instr_o     (mem_instr_o),
  .misalign_o      (misalign_o),
  .illegal_o       (illegal_o)
);

// File: tb/test_pkt_issue_split.sv
module test_pkt_issue_split;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned AW = 32;

  localparam logic [31:0] W_NOP   = 32'h0000_0013;
  localparam logic [31:0] W_ADD   = 32'h0031_00B3;
  localparam logic [31:0] W_ADDI  = 32'h0050_0093;
  localparam logic [31:0] W_NEAR  = 32'h0010_0013;
  localparam logic [31:0] W_BEQ   = 32'h0000_0063;
  localparam logic [31:0] W_JAL   = 32'h0000_006F;
  localparam logic [31:0] W_JALR  = 32'h0000_8067;
  localparam logic [31:0] W_LW    = 32'h0000_A283;
  localparam logic [31:0] W_SW    = 32'h0050_A023;
  localparam logic [31:0] W_LUI   = 32'h0000_00B7;
  localparam logic [31:0] W_USE   = 32'h0052_8333;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fetch_valid_i = 1'b0;
  logic [63:0]   fetch_word_i = '0;
  logic          branch_taken_i = 1'b0;
  logic [AW-1:0] branch_target_i = '0;
  logic [AW-1:0] fetch_pc_o;
  logic          alu_valid_o, alu_branch_o, mem_valid_o, mem_store_o;
  logic          misalign_o, illegal_o;
  logic [31:0]   alu_instr_o, mem_instr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [AW-1:0] exp_pc = '0;

  always #(PERIOD/2) clk_i = ~clk_i;

  pkt_issue_split #(.AW(AW), .RESET_PC('0)) i_pkt_issue_split (
    .clk_i, .rst_ni, .fetch_valid_i, .fetch_word_i, .branch_taken_i, .branch_target_i,
    .fetch_pc_o, .alu_valid_o, .alu_instr_o, .alu_branch_o, .mem_valid_o,
    .mem_instr_o, .mem_store_o, .misalign_o, .illegal_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic step(input logic v, input logic [31:0] mem_w, input logic [31:0] alu_w,
                      input logic tk = 1'b0, input logic [AW-1:0] tg = '0);
    fetch_valid_i   = v;
    fetch_word_i    = {mem_w, alu_w};
    branch_taken_i  = tk;
    branch_target_i = tg;
    @(negedge clk_i);
    if (v) exp_pc = tk ? tg : exp_pc + 8;
    fetch_valid_i  = 1'b0;
    branch_taken_i = 1'b0;
  endtask

  task automatic lanes(input string req, input logic av, input logic mv,
                       input logic mis, input logic ill);
    chk({req, " alu_valid"}, 64'(alu_valid_o), 64'(av));
    chk({req, " mem_valid"}, 64'(mem_valid_o), 64'(mv));
    chk({req, " misalign"},  64'(misalign_o),  64'(mis));
    chk({req, " illegal"},   64'(illegal_o),   64'(ill));
    chk({req, " pc"},        64'(fetch_pc_o),  64'(exp_pc));
  endtask

  task automatic t_reset;
    lanes("R1 in reset", 0, 0, 0, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    lanes("R1 after release", 0, 0, 0, 0);
  endtask

  task automatic t_split;
    step(1, W_LW, W_ADD);
    lanes("R2 R8 alu+load", 1, 1, 0, 0);
    chk("R2 alu_instr", 64'(alu_instr_o), 64'(W_ADD));
    chk("R2 mem_instr", 64'(mem_instr_o), 64'(W_LW));
    chk("R3 op not ctrl", 64'(alu_branch_o), 64'd0);
    chk("R4 load not store", 64'(mem_store_o), 64'd0);
    step(1, W_SW, W_ADDI);
    lanes("R3 opimm", 1, 1, 0, 0);
    chk("R4 store flag", 64'(mem_store_o), 64'd1);
    chk("R3 opimm not ctrl", 64'(alu_branch_o), 64'd0);
  endtask

  task automatic t_ctrl;
    logic [31:0] ws [3] = '{W_BEQ, W_JAL, W_JALR};
    for (int i = 0; i < 3; i++) begin
      step(1, W_SW, ws[i]);
      lanes("R3 ctrl", 1, 1, 0, 0);
      chk("R3 ctrl flag", 64'(alu_branch_o), 64'd1);
      chk("R2 ctrl instr", 64'(alu_instr_o), 64'(ws[i]));
    end
  endtask

  task automatic t_nop;
    step(1, W_NOP, W_ADD);
    lanes("R5 mem nop", 1, 0, 0, 0);
    step(1, W_SW, W_NOP);
    lanes("R5 alu nop", 0, 1, 0, 0);
    step(1, W_NOP, W_NOP);
    lanes("R5 R8 both nop", 0, 0, 0, 0);
    step(1, W_NOP, W_NEAR);
    lanes("R5 near nop issues", 1, 0, 0, 0);
  endtask

  task automatic t_illegal;
    step(1, W_ADD, W_ADD);
    lanes("R6 alu in mem slot", 0, 0, 0, 1);
    step(1, W_LW, W_LW);
    lanes("R6 load in alu slot", 0, 0, 0, 1);
    step(1, W_BEQ, W_NOP);
    lanes("R6 branch in mem slot", 0, 0, 0, 1);
    step(1, W_LW, W_LUI);
    lanes("R6 unknown opcode", 0, 0, 0, 1);
    step(1, W_LW, W_ADD);
    lanes("R6 recovers", 1, 1, 0, 0);
  endtask

  task automatic t_idle;
    step(0, W_LW, W_ADD);
    lanes("R10 idle", 0, 0, 0, 0);
    step(0, W_LW, W_ADD, 1'b1, 32'h0000_0400);
    lanes("R10 idle ignores taken", 0, 0, 0, 0);
  endtask

  task automatic t_redirect;
    step(1, W_SW, W_BEQ, 1'b1, 32'h0000_0100);
    lanes("R9 redirect", 1, 1, 0, 0);
    step(1, W_LW, W_ADD);
    lanes("R9 R8 after redirect", 1, 1, 0, 0);
  endtask

  task automatic t_misalign;
    step(1, W_NOP, W_JAL, 1'b1, 32'h0000_0104);
    lanes("R9 to odd target", 1, 0, 0, 0);
    step(1, W_LW, W_ADD);
    lanes("R7 misaligned", 0, 0, 1, 0);
    step(1, W_ADD, W_LW);
    lanes("R7 misalign wins over illegal", 0, 0, 1, 0);
    step(1, W_NOP, W_JAL, 1'b1, 32'h0000_0200);
    lanes("R7 R9 redirect out", 0, 0, 1, 0);
    step(1, W_LW, W_ADD);
    lanes("R7 aligned again", 1, 1, 0, 0);
  endtask

  task automatic t_no_hazard;
    step(1, W_LW, W_NOP);
    lanes("R11 load", 0, 1, 0, 0);
    step(1, W_NOP, W_USE);
    lanes("R11 consumer issues", 1, 0, 0, 0);
    chk("R11 consumer instr", 64'(alu_instr_o), 64'(W_USE));
  endtask

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_split();
    t_ctrl();
    t_nop();
    t_illegal();
    t_idle();
    t_redirect();
    t_misalign();
    t_no_hazard();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule